// File: doc/BRIEF.md
# Power-Down Message Broadcast and Acknowledge Collector

This block runs the turn-off handshake that comes before a platform power-down. Software writes a send bit. The block then offers one turn-off message to each downstream link port that is enabled at that moment. The system-interface port is never a target. Each message goes out through a request/grant handshake with that port's transmit logic.

A port whose link sits in the L2 low-power state is not asked to send. Its request waits until the link reports L0 again, and the send bit stays set for the whole wait. Starting a send while any target link is in L2 also produces a surprise link-down error pulse. The pulse carries a mask of the affected ports.

Acknowledge pulses return from the link ports. One counts only if it comes from a target port that has already had its message granted. When every target has acknowledged, a sticky acknowledge bit is set, and software clears it by writing 1. The system-interface port has index 4 in the acknowledge vector and never acknowledges legitimately. Any pulse seen there is reported as a master abort and does not count toward completion.

Top module: `pmto_turnoff`

## Requirements
- R1: After reset, send_pending, ack_all, msg_req, sys_ack_abort, err_surprise_down and err_down_ports are all 0.
- R2: A write with reg_wr_en=1 and reg_wr_send=1 while send_pending=0 sets send_pending on the next clock edge. The target set is the value of link_enable on that same edge. The same write while send_pending=1 is ignored, and no port that was already granted is requested again.
- R3: msg_req[i] is high only while send_pending=1, port i is in the target set, port i has not yet been granted, and its link is in L0. A port whose link_enable bit was 0 when the send was accepted is never requested.
- R4: link_state holds 2 bits per port; port i uses bits [2i+1:2i], with 00=L0, 01=L1, 10=L2 and 11=training. While a target link is not in L0, its request stays low and send_pending stays 1. The request rises in the same cycle that the link reports L0.
- R5: A cycle with msg_req[i] and msg_grant[i] both high marks port i as sent, and msg_req[i] is low from the next cycle on. send_pending clears on the edge that grants the last ungranted target port. With an empty target set it clears one cycle after it was set.
- R6: ack_all sets on the edge that samples the last missing acknowledge from the target set. An acknowledge on ack_in[i] counts only if port i is a target and was granted on an earlier edge. Any other acknowledge is ignored. With an empty target set, ack_all sets on the edge after the send is accepted.
- R7: ack_in[4] belongs to the system-interface port. It never counts toward completion. Each cycle it is high produces a one-cycle sys_ack_abort pulse on the next edge.
- R8: A write with reg_wr_en=1 and reg_wr_ack_clr=1 clears ack_all. If completion sets ack_all on the same edge, the set wins.
- R9: When a send is accepted while any enabled link port reports L2, err_surprise_down pulses for one cycle starting at the accepting edge. err_down_ports then shows those ports, one bit per port index, and is 0 at all other times.
- R10: Accepting a new send discards the sent and acknowledged records of the previous round. Every target is requested again, and acknowledges from the earlier round do not count toward the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_send | input | 1 | Write data: 1 requests a turn-off broadcast |
| reg_wr_ack_clr | input | 1 | Write data: 1 clears the acknowledge bit |
| send_pending | output | 1 | Send bit: set by software, cleared by hardware once every target has been granted |
| ack_all | output | 1 | Acknowledge bit: every target acknowledged |
| link_enable | input | 4 | Per-link-port enable mask |
| link_state | input | 8 | Per-link-port state, 2 bits each |
| msg_req | output | 4 | Per-port turn-off message request |
| msg_grant | input | 4 | Per-port message grant |
| ack_in | input | 5 | Per-port acknowledge pulses; bit 4 is the system-interface port |
| sys_ack_abort | output | 1 | Master-abort pulse for an acknowledge on the system-interface port |
| err_surprise_down | output | 1 | Surprise link-down error pulse |
| err_down_ports | output | 4 | Ports that were in L2 when the error was logged |

## Verification
A sent record that is lost shows up as a request being raised again right after a grant. A sent record that is set too early shows up as send_pending falling while a link is still in L2. Either fault appears within one cycle of the grant or of the link change. A stale acknowledged record, or an acknowledge that is counted before its grant, makes ack_all rise one edge too early. The tests therefore place early, foreign and system-port acknowledges before the real ones and check ack_all after every pulse. A wrong target snapshot appears immediately as a wrong msg_req pattern in the cycle after the send is accepted.

// File: rtl/pmto_pkg.sv
// Shared types for the turn-off broadcaster.
// Assumes link state arrives as a 2-bit code per port.
package pmto_pkg;

    typedef enum logic [1:0] {
        LS_L0    = 2'b00,
        LS_L1    = 2'b01,
        LS_L2    = 2'b10,
        LS_TRAIN = 2'b11
    } link_st_t;

endpackage

// File: rtl/pmto_lane.sv
// One link port lane. It keeps the per-port sent and acknowledged records
// and derives the request and the qualified grant and acknowledge events.
// Assumes clr pulses for one cycle when a new send is accepted.
module pmto_lane
    import pmto_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       active,
    input  logic       target,
    input  logic [1:0] link_st,
    input  logic       gnt,
    input  logic       ack,
    output logic       req,
    output logic       grant_hit,
    output logic       ack_hit,
    output logic       sent,
    output logic       acked,
    output logic       in_l2
);

    logic in_l0;

    // Decode the link state of this port
    always_comb begin
        in_l0 = (link_st == LS_L0);
        in_l2 = (link_st == LS_L2);
    end

    // Request while the round is active, this port is a target, not yet sent, and the link is up
    always_comb begin
        req       = active && target && !sent && in_l0;
        grant_hit = req && gnt;
        ack_hit   = ack && target && sent;
    end

    // Sent record: cleared by a new round, set by a grant
    always_ff @(posedge clk) begin
        if (!rst_n)         sent <= 1'b0;
        else if (clr)       sent <= 1'b0;
        else if (grant_hit) sent <= 1'b1;
    end

    // Acknowledged record: cleared by a new round, set by a qualified acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       acked <= 1'b0;
        else if (clr)     acked <= 1'b0;
        else if (ack_hit) acked <= 1'b1;
    end

endmodule

// File: rtl/pmto_ctrl.sv
// Round controller. It owns the send bit, the acknowledge bit, the target
// snapshot and the surprise link-down error log.
// Assumes the lane vectors are indexed by port number.
module pmto_ctrl #(
    parameter int NUM_LINK = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_send,
    input  logic                wr_ackclr,
    input  logic [NUM_LINK-1:0] link_en,
    input  logic [NUM_LINK-1:0] l2_vec,
    input  logic [NUM_LINK-1:0] sent_vec,
    input  logic [NUM_LINK-1:0] acked_vec,
    input  logic [NUM_LINK-1:0] grant_hit_vec,
    input  logic [NUM_LINK-1:0] ack_hit_vec,
    output logic                accept,
    output logic                send_bit,
    output logic                ack_bit,
    output logic [NUM_LINK-1:0] target,
    output logic                err_pulse,
    output logic [NUM_LINK-1:0] err_ports
);

    logic                collecting;
    logic                all_sent;
    logic                all_acked;
    logic [NUM_LINK-1:0] sent_nx;
    logic [NUM_LINK-1:0] acked_nx;
    logic [NUM_LINK-1:0] down_now;

    // Accept a new send only when none is pending; work out the completion conditions
    always_comb begin
        accept    = wr_en && wr_send && !send_bit;
        sent_nx   = sent_vec | grant_hit_vec;
        acked_nx  = acked_vec | ack_hit_vec;
        all_sent  = ((sent_nx & target) == target);
        all_acked = ((acked_nx & target) == target);
        down_now  = link_en & l2_vec;
    end

    // Target snapshot taken at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)      target <= '0;
        else if (accept) target <= link_en;
    end

    // Send bit: set by software, cleared by hardware once every target is granted
    always_ff @(posedge clk) begin
        if (!rst_n)                    send_bit <= 1'b0;
        else if (accept)               send_bit <= 1'b1;
        else if (send_bit && all_sent) send_bit <= 1'b0;
    end

    // Collection window: open from acceptance until every target has acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)                         collecting <= 1'b0;
        else if (accept)                    collecting <= 1'b1;
        else if (collecting && all_acked)   collecting <= 1'b0;
    end

    // Acknowledge bit: set on completion, cleared by write-1; the set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ack_bit <= 1'b0;
        else if (collecting && all_acked && !accept)  ack_bit <= 1'b1;
        else if (wr_en && wr_ackclr)                  ack_bit <= 1'b0;
    end

    // Error log: one pulse per accepted send that finds a target link in L2
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_ports <= '0;
        end else begin
            err_pulse <= accept && (|down_now);
            err_ports <= accept ? down_now : '0;
        end
    end

endmodule

// File: rtl/pmto_sys_filter.sv
// System-interface port filter. An acknowledge on that port is never
// legitimate, so each one is turned into a registered master-abort pulse.
// Assumes the acknowledge is a level sampled once per cycle.
module pmto_sys_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_ack,
    output logic abort
);

    // Register the abort report
    always_ff @(posedge clk) begin
        if (!rst_n) abort <= 1'b0;
        else        abort <= sys_ack;
    end

endmodule

// File: rtl/pmto_turnoff.sv
// Top of the turn-off broadcaster. It instantiates one lane per link port,
// the round controller and the system-port filter.
// Assumes the system-interface port has index NUM_LINK in ack_in.
module pmto_turnoff #(
    parameter int NUM_LINK = 4,
    localparam int NUM_PORTS = NUM_LINK + 1,
    localparam int ST_W      = 2 * NUM_LINK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic                 reg_wr_send,
    input  logic                 reg_wr_ack_clr,
    output logic                 send_pending,
    output logic                 ack_all,
    input  logic [NUM_LINK-1:0]  link_enable,
    input  logic [ST_W-1:0]      link_state,
    output logic [NUM_LINK-1:0]  msg_req,
    input  logic [NUM_LINK-1:0]  msg_grant,
    input  logic [NUM_PORTS-1:0] ack_in,
    output logic                 sys_ack_abort,
    output logic                 err_surprise_down,
    output logic [NUM_LINK-1:0]  err_down_ports
);

    logic                accept;
    logic [NUM_LINK-1:0] target;
    logic [NUM_LINK-1:0] sent_vec;
    logic [NUM_LINK-1:0] acked_vec;
    logic [NUM_LINK-1:0] grant_hit_vec;
    logic [NUM_LINK-1:0] ack_hit_vec;
    logic [NUM_LINK-1:0] l2_vec;

    pmto_ctrl #(.NUM_LINK(NUM_LINK)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (reg_wr_en),
        .wr_send       (reg_wr_send),
        .wr_ackclr     (reg_wr_ack_clr),
        .link_en       (link_enable),
        .l2_vec        (l2_vec),
        .sent_vec      (sent_vec),
        .acked_vec     (acked_vec),
        .grant_hit_vec (grant_hit_vec),
        .ack_hit_vec   (ack_hit_vec),
        .accept        (accept),
        .send_bit      (send_pending),
        .ack_bit       (ack_all),
        .target        (target),
        .err_pulse     (err_surprise_down),
        .err_ports     (err_down_ports)
    );

    for (genvar gi = 0; gi < NUM_LINK; gi++) begin : g_lane
        pmto_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (accept),
            .active    (send_pending),
            .target    (target[gi]),
            .link_st   (link_state[2*gi +: 2]),
            .gnt       (msg_grant[gi]),
            .ack       (ack_in[gi]),
            .req       (msg_req[gi]),
            .grant_hit (grant_hit_vec[gi]),
            .ack_hit   (ack_hit_vec[gi]),
            .sent      (sent_vec[gi]),
            .acked     (acked_vec[gi]),
            .in_l2     (l2_vec[gi])
        );
    end

    pmto_sys_filter u_sys (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_ack (ack_in[NUM_LINK]),
        .abort   (sys_ack_abort)
    );

endmodule

// File: rtl/pmto_checker.sv
// Property checker for the turn-off broadcaster, bound to the top module.
// Assumes it sees only the top-level ports.
module pmto_checker #(
    parameter int NUM_LINK = 4,
    localparam int NUM_PORTS = NUM_LINK + 1,
    localparam int ST_W      = 2 * NUM_LINK
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_en,
    input logic                 reg_wr_send,
    input logic                 send_pending,
    input logic [ST_W-1:0]      link_state,
    input logic [NUM_LINK-1:0]  msg_req,
    input logic [NUM_LINK-1:0]  msg_grant,
    input logic [NUM_PORTS-1:0] ack_in,
    input logic                 sys_ack_abort,
    input logic                 err_surprise_down
);

    AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (|msg_req) |-> send_pending); // R3

    AST_PENDING_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_pending) |-> $past(reg_wr_en && reg_wr_send)); // R2

    AST_SYS_ACK_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in[NUM_LINK] |=> sys_ack_abort); // R7

    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_surprise_down |-> $past(reg_wr_en && reg_wr_send)); // R9

    for (genvar gi = 0; gi < NUM_LINK; gi++) begin : g_port
        AST_REQ_ONLY_IN_L0: assert property (@(posedge clk) disable iff (!rst_n)
            msg_req[gi] |-> (link_state[2*gi +: 2] == 2'b00)); // R4

        AST_REQ_DROPS_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_req[gi] && msg_grant[gi]) |=> !msg_req[gi]); // R5
    end

endmodule

bind pmto_turnoff pmto_checker #(.NUM_LINK(NUM_LINK)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .reg_wr_en         (reg_wr_en),
    .reg_wr_send       (reg_wr_send),
    .send_pending      (send_pending),
    .link_state        (link_state),
    .msg_req           (msg_req),
    .msg_grant         (msg_grant),
    .ack_in            (ack_in),
    .sys_ack_abort     (sys_ack_abort),
    .err_surprise_down (err_surprise_down)
);

// File: tb/sim_pmto_turnoff.sv
// Directed bench for the turn-off broadcaster: one task per scenario.
module sim_pmto_turnoff;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_wr_send = 1'b0;
    logic       reg_wr_ack_clr = 1'b0;
    logic       send_pending;
    logic       ack_all;
    logic [3:0] link_enable = 4'h0;
    logic [7:0] link_state = 8'h00;
    logic [3:0] msg_req;
    logic [3:0] msg_grant = 4'h0;
    logic [4:0] ack_in = 5'h0;
    logic       sys_ack_abort;
    logic       err_surprise_down;
    logic [3:0] err_down_ports;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pmto_turnoff u0 (
        .clk               (clk),
        .rst_n             (rst_n),
        .reg_wr_en         (reg_wr_en),
        .reg_wr_send       (reg_wr_send),
        .reg_wr_ack_clr    (reg_wr_ack_clr),
        .send_pending      (send_pending),
        .ack_all           (ack_all),
        .link_enable       (link_enable),
        .link_state        (link_state),
        .msg_req           (msg_req),
        .msg_grant         (msg_grant),
        .ack_in            (ack_in),
        .sys_ack_abort     (sys_ack_abort),
        .err_surprise_down (err_surprise_down),
        .err_down_ports    (err_down_ports)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic snd, input logic clr);
        reg_wr_en = 1'b1; reg_wr_send = snd; reg_wr_ack_clr = clr;
        cyc();
        reg_wr_en = 1'b0; reg_wr_send = 1'b0; reg_wr_ack_clr = 1'b0;
    endtask

    task automatic grant(input logic [3:0] g);
        msg_grant = g; cyc(); msg_grant = 4'h0;
    endtask

    task automatic ack(input logic [4:0] a);
        ack_in = a; cyc(); ack_in = 5'h0;
    endtask

    task automatic t_reset;
        chk("R1 send_pending", send_pending, 0);
        chk("R1 ack_all", ack_all, 0);
        chk("R1 msg_req", msg_req, 0);
        chk("R1 abort", sys_ack_abort, 0);
        chk("R1 err", {err_surprise_down, err_down_ports}, 0);
    endtask

    task automatic t_basic;
        link_enable = 4'hF; link_state = 8'h00;
        wr(1, 0);
        chk("R2 pending set", send_pending, 1);
        chk("R3 all requested", msg_req, 4'hF);
        grant(4'b0101);
        chk("R5 granted drop", msg_req, 4'b1010);
        chk("R5 still pending", send_pending, 1);
        grant(4'b1010);
        chk("R5 req idle", msg_req, 0);
        chk("R5 pending clear", send_pending, 0);
        ack(5'b00111);
        chk("R6 partial", ack_all, 0);
        ack(5'b10000);
        chk("R7 abort pulse", sys_ack_abort, 1);
        chk("R7 no count", ack_all, 0);
        cyc();
        chk("R7 abort one cycle", sys_ack_abort, 0);
        ack(5'b01000);
        chk("R6 complete", ack_all, 1);
        wr(0, 1);
        chk("R8 cleared", ack_all, 0);
    endtask

    task automatic t_subset;
        link_enable = 4'b1010;
        wr(1, 0);
        chk("R3 enabled only", msg_req, 4'b1010);
        ack(5'b00011);
        grant(4'b1010);
        chk("R5 pending clear", send_pending, 0);
        ack(5'b01000);
        chk("R6 early and foreign ack ignored", ack_all, 0);
        ack(5'b00010);
        chk("R6 complete subset", ack_all, 1);
        wr(0, 1);
        link_enable = 4'b0001;
        wr(1, 0);
        grant(4'b0001);
        ack_in = 5'b00001; reg_wr_en = 1'b1; reg_wr_ack_clr = 1'b1;
        cyc();
        ack_in = 5'h0; reg_wr_en = 1'b0; reg_wr_ack_clr = 1'b0;
        chk("R8 set wins", ack_all, 1);
        wr(0, 1);
    endtask

    task automatic t_l2;
        link_enable = 4'b0101;
        link_state = 8'b00_10_00_00;
        wr(1, 0);
        chk("R9 err pulse", err_surprise_down, 1);
        chk("R9 err ports", err_down_ports, 4'b0100);
        chk("R4 held in L2", msg_req, 4'b0001);
        grant(4'b0001);
        chk("R9 err one cycle", {err_surprise_down, err_down_ports}, 0);
        chk("R4 pending kept", send_pending, 1);
        wr(1, 0);
        chk("R2 rewrite ignored", msg_req, 0);
        cyc(3);
        chk("R4 still pending", send_pending, 1);
        link_state = 8'h00;
        #1;
        chk("R4 released in L0", msg_req, 4'b0100);
        cyc();
        grant(4'b0100);
        chk("R5 pending clear after L0", send_pending, 0);
        ack(5'b00101);
        chk("R6 complete after L2", ack_all, 1);
        wr(0, 1);
    endtask

    task automatic t_empty;
        link_enable = 4'h0;
        wr(1, 0);
        chk("R5 empty pending", send_pending, 1);
        chk("R3 empty no req", msg_req, 0);
        cyc();
        chk("R5 empty clears", send_pending, 0);
        chk("R6 empty complete", ack_all, 1);
        wr(0, 1);
    endtask

    task automatic t_new_round;
        link_enable = 4'b0001;
        wr(1, 0);
        grant(4'b0001);
        ack(5'b00001);
        chk("R6 round one", ack_all, 1);
        wr(0, 1);
        wr(1, 0);
        chk("R10 re-requested", msg_req, 4'b0001);
        cyc(2);
        chk("R10 old ack discarded", ack_all, 0);
        grant(4'b0001);
        ack(5'b00001);
        chk("R10 round two", ack_all, 1);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_basic();
        t_subset();
        t_l2();
        t_empty();
        t_new_round();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule